// File: doc/BRIEF.md
# Valley Trigger Qualifier for a Quasi-Resonant Boost Switch

This block sits between the demagnetization comparator of a quasi-resonant boost converter and the switch modulator. The comparator output is high while the auxiliary winding voltage is above its threshold. When the inductor has given up its stored energy, the drain node rings, and each high-to-low transition of the comparator marks the approach to a valley of that ringing. The block turns such a transition into a single-clock start-of-cycle pulse. It does this only when the comparator was high without a break for a minimum number of clock samples, so short spikes on the comparator line cannot start a switching cycle.

The modulator supplies an enable that says the minimum off time has passed. A qualified valley that arrives while this enable is low is skipped, and the block waits for a later valley. The switching frequency is variable, so a cycle can start on the second, third or any later valley. A small counter reports how many qualified valleys have been skipped since the last trigger.

The comparator input is asynchronous and passes through a synchronizer chain before any decision is made. The qualification length is given in clock cycles. At a 100 MHz clock, the default of 20 cycles is a 200 ns minimum high time.

Top module: `valley_trig_qual`

## Requirements
- R1: After reset, and while reset is held, `trig` is 0 and `skip_cnt` is 0. Asserting reset clears a nonzero skip count.
- R2: A falling edge of `cmp_in` that follows a high run of at least QUAL_CYCLES clock samples gives a trigger pulse. With the default two synchronizer stages, `trig` is high in the clock cycle after the third rising edge following the fall.
- R3: A falling edge that follows a high run shorter than QUAL_CYCLES samples gives no pulse. Any low sample restarts the run, so two short highs split by a one-cycle low do not add up.
- R4: A rising edge never gives a pulse, and neither does a comparator that stays high. A high run of any length above QUAL_CYCLES still qualifies, because the run counter saturates, and it gives exactly one pulse at its fall.
- R5: A qualified fall gives a pulse only if `off_done` is high in the cycle the fall is detected. Otherwise that valley is skipped and no pulse is issued for it.
- R6: Each skipped qualified valley raises `skip_cnt` by exactly one. Unqualified falling edges leave `skip_cnt` unchanged.
- R7: `skip_cnt` returns to 0 on the same clock edge that raises `trig`.
- R8: `skip_cnt` saturates at 2^SKIP_W-1 (7 for the default SKIP_W of 3) and does not wrap.
- R9: Every trigger pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Asynchronous demagnetization comparator output, high while the winding is above threshold |
| off_done | input | 1 | Minimum off time elapsed; high allows a trigger |
| trig | output | 1 | One-cycle start-of-cycle pulse on a qualified valley |
| skip_cnt | output | SKIP_W | Qualified valleys skipped since the last trigger, saturating |

## Verification
The bound checker watches every cycle for these properties: a pulse is one cycle wide, a pulse needs the enable in the cycle before it, a pulse comes right after a synchronized fall, and the high run before that fall was at least the qualification length. It also checks that the skip count clears when a pulse is issued, that it otherwise only steps up by one, and that it holds once saturated. The bench scenarios cover the things a property cannot cover by itself. These are the exact latency from the raw comparator pin, the boundary at exactly QUAL_CYCLES and one sample short of it, and a glitch that splits a high run. They also show that a long high gives one pulse and no more, and that an unqualified edge leaves the count alone.

// File: rtl/vtq_pkg.sv
package vtq_pkg;

   // number of bits needed to hold every value from 0 up to max_val
   function automatic int unsigned width_for(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((max_val >> w) != 0) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/vtq_sync.sv
module vtq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("vtq_sync: STAGES must be at least 2");
      end

      if (STAGES == 2) begin : g_two
         logic meta_q, sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               sync_q <= 1'b0;
            end else begin
               meta_q <= d_async;
               sync_q <= meta_q;
            end
         end
         assign q_sync = sync_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vtq_run_qual.sv
module vtq_run_qual
   import vtq_pkg::*;
#(
   parameter int unsigned QUAL_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic run_ok
);

   localparam int unsigned CW = width_for(QUAL_CYCLES);

   generate
      if (QUAL_CYCLES == 0) begin : g_bad
         $error("vtq_run_qual: QUAL_CYCLES must be nonzero");
      end

      if (QUAL_CYCLES == 1) begin : g_single
         // one high sample is enough: a flop of the previous level
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl;
         end
         assign run_ok = prev_q;
      end else begin : g_count
         localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_q <= '0;
            else if (!lvl)         run_q <= '0;
            else if (run_q != LIMIT) run_q <= run_q + 1'b1;
         end
         assign run_ok = (run_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/vtq_edge.sv
module vtq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic run_ok,
   input  logic allow,
   output logic fire,
   output logic skip_evt,
   output logic pulse
);

   logic lvl_d;
   logic good_fall;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign good_fall = lvl_d & ~lvl & run_ok;
   assign fire      = good_fall & allow;
   assign skip_evt  = good_fall & ~allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire;
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/vtq_skip_cnt.sv
module vtq_skip_cnt #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W == 0) begin : g_bad
         $error("vtq_skip_cnt: W must be nonzero");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr)                  cnt_q <= '0;
      else if (inc && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/valley_trig_qual.sv
module valley_trig_qual #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned QUAL_CYCLES = 20,
   parameter int unsigned SKIP_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_in,
   input  logic              off_done,
   output logic              trig,
   output logic [SKIP_W-1:0] skip_cnt
);

   logic s_lvl;
   logic run_ok;
   logic fire;
   logic skip_evt;

   vtq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (cmp_in),
      .q_sync  (s_lvl)
   );

   vtq_run_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (s_lvl),
      .run_ok (run_ok)
   );

   vtq_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (s_lvl),
      .run_ok   (run_ok),
      .allow    (off_done),
      .fire     (fire),
      .skip_evt (skip_evt),
      .pulse    (trig)
   );

   vtq_skip_cnt #(.W(SKIP_W)) u_skip (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fire),
      .inc   (skip_evt),
      .cnt   (skip_cnt)
   );

endmodule

// File: rtl/vtq_checker.sv
module vtq_checker #(
   parameter int unsigned QUAL_CYCLES = 20,
   parameter int unsigned SKIP_W      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lvl,
   input logic              off_done,
   input logic              trig,
   input logic [SKIP_W-1:0] skip_cnt
);

   // independent run-length tracker of the synchronized level
   int unsigned run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_len <= 0;
      else if (!lvl)                 run_len <= 0;
      else if (run_len < QUAL_CYCLES) run_len <= run_len + 1;
   end

   p_one_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> !trig);

   p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(off_done));

   p_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (!$past(lvl, 1) && $past(lvl, 2)));

   p_long_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> ($past(run_len) >= QUAL_CYCLES));

   p_clear_on_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (skip_cnt == '0));

   p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && skip_cnt != $past(skip_cnt)) |-> (skip_cnt == SKIP_W'($past(skip_cnt) + 1'b1)));

   p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && $past(skip_cnt) == {SKIP_W{1'b1}}) |-> (skip_cnt == {SKIP_W{1'b1}}));

endmodule

bind valley_trig_qual vtq_checker #(
   .QUAL_CYCLES (QUAL_CYCLES),
   .SKIP_W      (SKIP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lvl      (s_lvl),
   .off_done (off_done),
   .trig     (trig),
   .skip_cnt (skip_cnt)
);

// File: tb/valley_trig_qual_test.sv
module valley_trig_qual_test;

   localparam int QUAL = 20;
   localparam int SW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmp_in = 1'b0;
   logic          off_done = 1'b0;
   logic          trig;
   logic [SW-1:0] skip_cnt;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   valley_trig_qual #(.SYNC_STAGES(2), .QUAL_CYCLES(QUAL), .SKIP_W(SW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_in   (cmp_in),
      .off_done (off_done),
      .trig     (trig),
      .skip_cnt (skip_cnt)
   );

   // {high length[23:8], enable[7], expected pulses[6:4], expected count[3:0]}
   localparam logic [23:0] VEC [8] = '{
      24'h001990,  // long enough, enabled
      24'h001380,  // one sample short
      24'h001490,  // exactly the minimum
      24'h001E01,  // skipped
      24'h000501,  // short edge while waiting: not counted
      24'h002802,  // second skip
      24'h001590,  // taken, count cleared
      24'h000380   // glitch, enabled
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // high for h cycles then low; counts pulses and widest pulse over the tail
   task automatic valley(input int h, input bit en, output int np, output int wmax);
      int w;
      np = 0; wmax = 0; w = 0;
      @(negedge clk);
      off_done = en;
      cmp_in = 1'b1;
      repeat (h) begin
         @(negedge clk);
         if (trig) np++;
      end
      cmp_in = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (trig) begin
            if (w == 0) np++;
            w++;
            if (w > wmax) wmax = w;
         end else w = 0;
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int np, wmax;
      repeat (3) @(negedge clk);
      check(trig == 1'b0, "R1 trig in reset", int'(trig), 0);
      check(skip_cnt == '0, "R1 count in reset", int'(skip_cnt), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // table walk
      foreach (VEC[k]) begin
         valley(int'(VEC[k][23:8]), VEC[k][7], np, wmax);
         check(np == int'(VEC[k][6:4]), "R2 R3 R5 pulse count", np, int'(VEC[k][6:4]));
         check(skip_cnt == VEC[k][SW-1:0], "R6 R7 skip count", int'(skip_cnt), int'(VEC[k][3:0]));
      end

      // R2 exact latency and R9 width
      off_done = 1'b1;
      cmp_in = 1'b1;
      repeat (25) @(negedge clk);
      cmp_in = 1'b0;
      @(negedge clk); check(trig == 1'b0, "R2 latency +1", int'(trig), 0);
      @(negedge clk); check(trig == 1'b0, "R2 latency +2", int'(trig), 0);
      @(negedge clk); check(trig == 1'b1, "R2 latency +3", int'(trig), 1);
      @(negedge clk); check(trig == 1'b0, "R9 width", int'(trig), 0);
      repeat (4) @(negedge clk);

      // R3 glitch splits the run: 15 high, 1 low, 10 high
      cmp_in = 1'b1; repeat (15) @(negedge clk);
      cmp_in = 1'b0; @(negedge clk);
      valley(10, 1'b1, np, wmax);
      check(np == 0, "R3 split run", np, 0);
      // 15 high, 1 low, 25 high -> the second run alone qualifies
      cmp_in = 1'b1; repeat (15) @(negedge clk);
      cmp_in = 1'b0; @(negedge clk);
      valley(25, 1'b1, np, wmax);
      check(np == 1, "R3 second run qualifies", np, 1);

      // R4 long high: no pulse while high, one pulse at fall, one wide
      valley(300, 1'b1, np, wmax);
      check(np == 1, "R4 long high one pulse", np, 1);
      check(wmax == 1, "R9 long high width", wmax, 1);

      // R8 saturation after nine skips, then R7 clear
      for (int i = 0; i < 9; i++) valley(22, 1'b0, np, wmax);
      check(skip_cnt == 3'd7, "R8 saturation", int'(skip_cnt), 7);
      valley(5, 1'b0, np, wmax);
      check(skip_cnt == 3'd7, "R6 unqualified edge ignored", int'(skip_cnt), 7);
      valley(22, 1'b1, np, wmax);
      check(np == 1, "R5 enabled after skips", np, 1);
      check(skip_cnt == '0, "R7 cleared on trigger", int'(skip_cnt), 0);

      // R1 reset clears a nonzero count
      valley(22, 1'b0, np, wmax);
      valley(22, 1'b0, np, wmax);
      check(skip_cnt == 3'd2, "R6 two skips", int'(skip_cnt), 2);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(skip_cnt == '0, "R1 reset clears count", int'(skip_cnt), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule